// File: doc/BRIEF.md
# Generalized N-State Reset Register

This block is a state register whose only moves are "stay" and "jump to a chosen state". It has `NUM_STATES` states and one request line per state. If no line is raised, the stored state is held. If exactly one line `j` is raised, the next clock edge puts the machine in state `j`, whatever state it was in.

The state is not kept as a one-hot vector. It is packed in binary into `CODE_W = max(1, ceil(log2 NUM_STATES))` two-state set/clear cells that sit side by side. A single request turns into a set or clear command for each cell. A three-state instance therefore uses two cells: the three states take three of the four cell encodings and the fourth is never reached.

Raising more than one request in the same cycle is not a legal command. The block flags that cycle on an error output and keeps its state as it was. Besides the packed code, the block also gives a one-hot decode of the state, for the logic that consumes it.

Top module: `nstate_reset_reg`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the machine enters state 0. After reset, `state_code` reads 0 and `state_onehot` has only bit 0 set.
- R2: If `req` is all zeros at a rising edge, `state_code` keeps its value across that edge.
- R3: If exactly one bit `j` of `req` is set at a rising edge, `state_code` equals `j` after that edge, from every starting state.
- R4: `req_conflict` is high in the same cycle whenever two or more bits of `req` are set. There is no register on this path.
- R5: A cycle with two or more request bits set leaves `state_code` unchanged across the following edge.
- R6: `state_onehot` has exactly one bit set at all times, and that bit sits at index `state_code`.
- R7: `state_code` is `CODE_W = max(1, ceil(log2 NUM_STATES))` bits wide. It holds state `j` as the unsigned binary number `j`, with bit 0 as the LSB. For `NUM_STATES = 3` the codes are 00, 01 and 10. For `NUM_STATES = 5` they are 000 through 100.
- R8: `req_conflict` is low whenever at most one bit of `req` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes happen on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset to state 0 |
| req | input | NUM_STATES | Request lines; bit j asks for state j |
| state_code | output | CODE_W | Binary-packed current state |
| state_onehot | output | NUM_STATES | One-hot decode of the current state |
| req_conflict | output | 1 | High while more than one request is raised |

## Verification
A wrong cell value shows up on `state_code` and `state_onehot` one edge after the request that caused it. A packed code at or above `NUM_STATES` would also show as an all-zero one-hot vector. A conflict that gets acted on shows as a code change one edge after a multi-request cycle. A missing or late flag can be seen within that same cycle.

The bench sweeps every request pattern from every reachable state for a three-state and a five-state instance. It observes each result in the cycle the result is due.

// File: rtl/nsr_pkg.sv
// Package: shared sizing helper for the n-state reset register.
// Assumes state counts of 2 or more.
package nsr_pkg;

    // Width of the binary state code; at least one cell.
    function automatic int code_width(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/nsr_sr_cell.sv
// Module: nsr_sr_cell
// A two-state set/clear storage cell with synchronous active-low reset.
// Assumes set_i and clr_i are never high together (the request encoder
// guarantees this); if both were high, set would win.
module nsr_sr_cell #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);

    // Hold, set or clear the stored bit on each rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q_o <= RST_VAL;
        else if (set_i)
            q_o <= 1'b1;
        else if (clr_i)
            q_o <= 1'b0;
    end

endmodule

// File: rtl/nsr_req_encoder.sv
// Module: nsr_req_encoder
// Turns the request lines into per-cell set/clear commands.
// A single request j drives cell b to bit b of j. No request, or more
// than one request, drives no command and holds every cell.
// Assumes NUM_STATES <= 2**CODE_W.
module nsr_req_encoder #(
    parameter int NUM_STATES = 3,
    parameter int CODE_W     = 2
) (
    input  logic [NUM_STATES-1:0] req_i,
    output logic [CODE_W-1:0]     set_o,
    output logic [CODE_W-1:0]     clr_o,
    output logic                  multi_o
);

    logic [CODE_W-1:0] target;
    logic              seen;
    logic              valid;

    // Find the requested state index and detect a second request.
    always_comb begin
        target  = '0;
        seen    = 1'b0;
        multi_o = 1'b0;
        for (int j = 0; j < NUM_STATES; j++) begin
            if (req_i[j]) begin
                if (seen)
                    multi_o = 1'b1;
                seen   = 1'b1;
                target = target | CODE_W'(j);
            end
        end
    end

    assign valid = seen && !multi_o;

    // Split the target code into set and clear commands for each cell.
    always_comb begin
        set_o = valid ? target  : '0;
        clr_o = valid ? ~target : '0;
    end

endmodule

// File: rtl/nsr_onehot_dec.sv
// Module: nsr_onehot_dec
// Decodes the packed state code into a one-hot vector.
// Assumes only codes below NUM_STATES can occur.
module nsr_onehot_dec #(
    parameter int NUM_STATES = 3,
    parameter int CODE_W     = 2
) (
    input  logic [CODE_W-1:0]     code_i,
    output logic [NUM_STATES-1:0] onehot_o
);

    // One comparator per state.
    for (genvar j = 0; j < NUM_STATES; j++) begin : g_dec
        assign onehot_o[j] = (code_i == CODE_W'(j));
    end

endmodule

// File: rtl/nstate_reset_reg.sv
// Module: nstate_reset_reg
// n-state reset machine: it holds its state when no request is raised,
// and jumps to state j on request j. The state is packed in binary into
// CODE_W parallel set/clear cells. A cycle with more than one request is
// flagged on req_conflict and does not change the state.
// Assumes NUM_STATES >= 2.
module nstate_reset_reg #(
    parameter  int NUM_STATES = 3,
    localparam int CODE_W     = nsr_pkg::code_width(NUM_STATES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_STATES-1:0] req,
    output logic [CODE_W-1:0]     state_code,
    output logic [NUM_STATES-1:0] state_onehot,
    output logic                  req_conflict
);

    logic [CODE_W-1:0] cell_set;
    logic [CODE_W-1:0] cell_clr;

    nsr_req_encoder #(
        .NUM_STATES(NUM_STATES),
        .CODE_W    (CODE_W)
    ) u_enc (
        .req_i  (req),
        .set_o  (cell_set),
        .clr_o  (cell_clr),
        .multi_o(req_conflict)
    );

    // One two-state cell per code bit, all resetting to state 0.
    for (genvar b = 0; b < CODE_W; b++) begin : g_cell
        nsr_sr_cell #(
            .RST_VAL(1'b0)
        ) u_cell (
            .clk  (clk),
            .rst_n(rst_n),
            .set_i(cell_set[b]),
            .clr_i(cell_clr[b]),
            .q_o  (state_code[b])
        );
    end

    nsr_onehot_dec #(
        .NUM_STATES(NUM_STATES),
        .CODE_W    (CODE_W)
    ) u_dec (
        .code_i  (state_code),
        .onehot_o(state_onehot)
    );

endmodule

// File: rtl/nstate_reset_reg_chk.sv
// Module: nstate_reset_reg_chk
// Property checker bound to every nstate_reset_reg instance.
module nstate_reset_reg_chk #(
    parameter int NUM_STATES = 3,
    parameter int CODE_W     = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_STATES-1:0] req,
    input logic [CODE_W-1:0]     state_code,
    input logic [NUM_STATES-1:0] state_onehot,
    input logic                  req_conflict
);

    // R2: with no request, the state holds.
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (req == '0) |=> $stable(state_code));

    // R3: a single request j moves the state to j.
    for (genvar j = 0; j < NUM_STATES; j++) begin : g_tgt
        a_r3_jump_target: assert property (@(posedge clk) disable iff (!rst_n)
            (req == NUM_STATES'(1) << j) |=> (state_code == CODE_W'(j)));
    end

    // R4: several requests raise the flag.
    a_r4_conflict_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(req) > 1) |-> req_conflict);

    // R5: a flagged cycle does not change the state.
    a_r5_conflict_hold: assert property (@(posedge clk) disable iff (!rst_n)
        req_conflict |=> $stable(state_code));

    // R6: exactly one decode bit is set.
    a_r6_onehot_count: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(state_onehot) == 1);

    // R6: the set decode bit matches the code.
    a_r6_onehot_index: assert property (@(posedge clk) disable iff (!rst_n)
        state_onehot[state_code] == 1'b1);

    // R8: at most one request keeps the flag low.
    a_r8_no_false_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req) |-> !req_conflict);

endmodule

bind nstate_reset_reg nstate_reset_reg_chk #(
    .NUM_STATES(NUM_STATES),
    .CODE_W    (CODE_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req         (req),
    .state_code  (state_code),
    .state_onehot(state_onehot),
    .req_conflict(req_conflict)
);

// File: tb/nstate_reset_reg_tb.sv
`timescale 1ns/1ps
module nstate_reset_reg_tb;

    localparam int N3 = 3;
    localparam int W3 = 2;
    localparam int N5 = 5;
    localparam int W5 = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N3-1:0] req3 = '0;
    logic [N5-1:0] req5 = '0;
    logic [W3-1:0] code3;
    logic [W5-1:0] code5;
    logic [N3-1:0] oh3;
    logic [N5-1:0] oh5;
    logic          cf3;
    logic          cf5;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    nstate_reset_reg #(.NUM_STATES(N3)) u_dut (
        .clk(clk), .rst_n(rst_n), .req(req3),
        .state_code(code3), .state_onehot(oh3), .req_conflict(cf3)
    );

    nstate_reset_reg #(.NUM_STATES(N5)) u_dut5 (
        .clk(clk), .rst_n(rst_n), .req(req5),
        .state_code(code5), .state_onehot(oh5), .req_conflict(cf5)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int popc(input int v);
        int c = 0;
        for (int i = 0; i < 32; i++) c += (v >> i) & 1;
        return c;
    endfunction

    function automatic int lowest(input int v);
        for (int i = 0; i < 32; i++) if (((v >> i) & 1) != 0) return i;
        return -1;
    endfunction

    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state on both instances.
        chk("R1 code3", int'(code3), 0);
        chk("R1 oh3", int'(oh3), 1);
        chk("R1 code5", int'(code5), 0);
        chk("R1 oh5", int'(oh5), 1);
        rst_n = 1'b1;
        @(negedge clk);

        // Three-state instance: every start state times every request pattern.
        for (int s = 0; s < N3; s++) begin
            for (int p = 0; p < (1 << N3); p++) begin
                int exp;
                req3 = N3'(1 << s);
                @(negedge clk);
                chk("R3 setup3", int'(code3), s);
                req3 = N3'(p);
                #1;
                chk(popc(p) > 1 ? "R4 flag3" : "R8 flag3", int'(cf3), popc(p) > 1 ? 1 : 0);
                exp = (popc(p) == 1) ? lowest(p) : s;
                @(negedge clk);
                req3 = '0;
                chk(popc(p) == 0 ? "R2 hold3" : (popc(p) == 1 ? "R3 jump3" : "R5 keep3"),
                    int'(code3), exp);
                chk("R6 oh3", int'(oh3), 1 << exp);
                chk("R7 width3", $bits(code3), 2);
            end
        end

        // Five-state instance: every start state times every request pattern.
        for (int s = 0; s < N5; s++) begin
            for (int p = 0; p < (1 << N5); p++) begin
                int exp;
                req5 = N5'(1 << s);
                @(negedge clk);
                chk("R7 code5", int'(code5), s);
                req5 = N5'(p);
                #1;
                chk(popc(p) > 1 ? "R4 flag5" : "R8 flag5", int'(cf5), popc(p) > 1 ? 1 : 0);
                exp = (popc(p) == 1) ? lowest(p) : s;
                @(negedge clk);
                req5 = '0;
                chk(popc(p) == 0 ? "R2 hold5" : (popc(p) == 1 ? "R3 jump5" : "R5 keep5"),
                    int'(code5), exp);
                chk("R6 oh5", int'(oh5), 1 << exp);
            end
        end

        // R1: reset from a non-zero state, with a request raised at the same time.
        req5 = N5'(1 << 4);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 rereset5", int'(code5), 0);
        rst_n = 1'b1;
        req5 = '0;
        @(negedge clk);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule